// File: doc/BRIEF.md
# Mode-Controlled Addressable Bit Latch

This block is a bank of single-bit storage cells, one per output, written one bit at a time. A binary address picks the target cell and a single data bit supplies its new value. Two active-low controls, a write enable and a clear, combine into four modes: write the addressed bit, hold everything, write the addressed bit while zeroing all others (one-hot demultiplex), and zero everything.

Every update happens on the rising edge of the clock. The controls, address and data are sampled on that same edge. One cycle with the enable low is one write. The parallel outputs come straight from the cell flops, so they change only just after a clock edge.

The address width is a parameter. The number of outputs is two raised to that width, and the default of 3 gives eight outputs.

Top module: `addr_bit_latch`

## Requirements
- R1: Write mode (clr_n=1, we_n=0): at the clock edge, output bit `addr` takes `din` and every other output bit keeps its value.
- R2: Hold mode (clr_n=1, we_n=1): at the clock edge, no output bit changes, whatever `addr` and `din` are.
- R3: Demultiplex mode (clr_n=0, we_n=0): at the clock edge, output bit `addr` takes `din` and every other output bit becomes 0.
- R4: Clear mode (clr_n=0, we_n=1): at the clock edge, every output bit becomes 0.
- R5: The address is unsigned binary with its top bit most significant. Value k selects output bit k, so address 0 selects q[0] and address 7 selects q[7] at the default width.
- R6: When we_n goes from 0 to 1 with clr_n=1, every bit keeps the value it had after the last write cycle.
- R7: In write mode, moving the address between cycles leaves the previously addressed bit at its last written value.
- R8: In demultiplex mode, moving the address between cycles clears the previously addressed bit.
- R9: One clock in clear mode takes the outputs from any earlier state, including an unknown one, to all zero.
- R10: The output count is 2**ADDR_W. The default ADDR_W is 3, which gives 8 outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every update happens on its rising edge |
| clr_n | input | 1 | Active-low clear control, one of the two mode-select inputs |
| we_n | input | 1 | Active-low write enable, the other mode-select input |
| addr | input | ADDR_W | Binary index of the target bit |
| din | input | 1 | Data bit for the addressed cell |
| q | output | 2**ADDR_W | Parallel register contents |

## Verification
The bench goes after three kinds of error.

- **Address moves.** It moves the address while the enable stays low, in both write and demultiplex mode. A design that handled "other bits" wrongly would either wipe the old bit in write mode or leave it set in demultiplex mode.
- **Idle inputs in hold mode.** It toggles the address and data during hold mode and after the enable rises. A design that let the decoder leak through while idle would corrupt a stored bit.
- **Address order and mode encoding.** It walks a single one through every address in demultiplex mode, which catches a reversed or mis-weighted decoder. Long random runs over all four control pairs, compared with a reference array after every clock, catch a swapped mode encoding.

// File: rtl/abl_pkg.sv
// Package abl_pkg
// Purpose : shared mode type and control decode for the addressable bit latch.
// Assumes : both control inputs are active low.
package abl_pkg;

    // The four operating modes selected by the two control inputs.
    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } abl_mode_e;

    // Map the active-low clear and write-enable pair onto a mode.
    function automatic abl_mode_e decode_mode(input logic clr_n, input logic we_n);
        abl_mode_e m;
        case ({clr_n, we_n})
            2'b10:   m = MODE_WRITE;
            2'b11:   m = MODE_HOLD;
            2'b00:   m = MODE_DEMUX;
            default: m = MODE_CLEAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/abl_mode_dec.sv
// Module abl_mode_dec
// Purpose : turns the two control inputs into the per-cell control strobes
//           shared by every storage cell.
// Assumes : inputs are sampled by the cells on the same clock edge.
module abl_mode_dec
    import abl_pkg::*;
(
    input  logic      clr_n,
    input  logic      we_n,
    output abl_mode_e mode,
    output logic      load_sel,
    output logic      zero_unsel,
    output logic      zero_all
);

    // Decode the mode and derive the three strobes from it.
    always_comb begin
        mode       = decode_mode(clr_n, we_n);
        load_sel   = (mode == MODE_WRITE) || (mode == MODE_DEMUX);
        zero_unsel = (mode == MODE_DEMUX) || (mode == MODE_CLEAR);
        zero_all   = (mode == MODE_CLEAR);
    end

    // Immediate checks on strobe consistency.
    always_comb begin
        if (!$isunknown({clr_n, we_n})) begin
            // R4: clear zeroes unselected bits too and never loads.
            a_r4_clear_strobes: assert (!zero_all || (zero_unsel && !load_sel));
            // R2: hold asserts no strobe at all.
            a_r2_hold_quiet: assert (!(clr_n && we_n) || !(load_sel || zero_unsel || zero_all));
        end
    end

endmodule

// File: rtl/abl_addr_dec.sv
// Module abl_addr_dec
// Purpose : binary-to-one-hot decoder; output bit k is high for address k.
// Assumes : NUM_OUT equals 2**ADDR_W, so every address maps to exactly one bit.
module abl_addr_dec #(
    parameter int ADDR_W  = 3,
    parameter int NUM_OUT = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_OUT-1:0] sel
);

    // One comparator per output bit.
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_cmp
        assign sel[k] = (addr == ADDR_W'(k));
    end

    // Each known address must select exactly its own bit.
    always_comb begin
        if (!$isunknown(addr)) begin
            // R5: the selected bit is the one whose index equals the address.
            a_r5_onehot_index: assert ($countones(sel) == 1 && sel[addr]);
        end
    end

endmodule

// File: rtl/abl_bit_cell.sv
// Module abl_bit_cell
// Purpose : one storage bit with its next-state choice among load, zero and keep.
// Assumes : at most one of load/zero is effective per cycle; zero_all wins.
module abl_bit_cell (
    input  logic clk,
    input  logic sel,
    input  logic din,
    input  logic load_sel,
    input  logic zero_unsel,
    input  logic zero_all,
    output logic q
);

    logic nxt;

    // Choose the next value for this bit from the shared strobes.
    always_comb begin
        if (zero_all)
            nxt = 1'b0;
        else if (sel)
            nxt = load_sel ? din : q;
        else
            nxt = zero_unsel ? 1'b0 : q;
    end

    // Register the bit on the rising edge.
    always_ff @(posedge clk) begin
        q <= nxt;
    end

endmodule

// File: rtl/addr_bit_latch.sv
// Module addr_bit_latch
// Purpose : top of the addressable bit latch; a mode decoder, an address
//           decoder and 2**ADDR_W storage cells.
// Assumes : all inputs are synchronous to clk. Outputs are undefined until the
//           first cycle with clr_n low (clear or demultiplex).
module addr_bit_latch
    import abl_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     clr_n,
    input  logic                     we_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     din,
    output logic [(1<<ADDR_W)-1:0]   q
);

    localparam int NUM_OUT = 1 << ADDR_W;

    abl_mode_e          mode;
    logic               load_sel;
    logic               zero_unsel;
    logic               zero_all;
    logic [NUM_OUT-1:0] sel;

    abl_mode_dec u_mode (
        .clr_n      (clr_n),
        .we_n       (we_n),
        .mode       (mode),
        .load_sel   (load_sel),
        .zero_unsel (zero_unsel),
        .zero_all   (zero_all)
    );

    abl_addr_dec #(.ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT)) u_adec (
        .addr (addr),
        .sel  (sel)
    );

    // One storage cell per output bit.
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_cell
        abl_bit_cell u_cell (
            .clk        (clk),
            .sel        (sel[k]),
            .din        (din),
            .load_sel   (load_sel),
            .zero_unsel (zero_unsel),
            .zero_all   (zero_all),
            .q          (q[k])
        );
    end

    // Checker qualifier only: high once a clr_n-low cycle has defined every bit.
    logic chk_armed;
    always_ff @(posedge clk) begin
        chk_armed <= chk_armed | ~clr_n;
    end

    // R10: output count follows the address width.
    initial begin
        a_r10_width: assert ($bits(q) == (1 << ADDR_W));
    end

    // R1, R7: write mode loads the addressed bit and keeps the rest.
    a_r1_write_target: assert property (@(posedge clk) disable iff (!chk_armed)
        (mode == MODE_WRITE) |=> q[$past(addr)] == $past(din));
    a_r7_write_others: assert property (@(posedge clk) disable iff (!chk_armed)
        (mode == MODE_WRITE) |=> (q & ~$past(sel)) == ($past(q) & ~$past(sel)));

    // R2, R6: hold mode leaves every bit unchanged.
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!chk_armed)
        (mode == MODE_HOLD) |=> $stable(q));

    // R3, R8: demultiplex mode loads the addressed bit and zeroes the rest.
    a_r3_demux_target: assert property (@(posedge clk) disable iff (!chk_armed)
        (mode == MODE_DEMUX) |=> q[$past(addr)] == $past(din));
    a_r8_demux_others: assert property (@(posedge clk) disable iff (!chk_armed)
        (mode == MODE_DEMUX) |=> (q & ~$past(sel)) == '0);

    // R4, R9: clear mode zeroes every bit.
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!chk_armed)
        (mode == MODE_CLEAR) |=> q == '0);

endmodule

// File: tb/tb_addr_bit_latch.sv
module tb_addr_bit_latch;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 3;
    localparam int N          = 1 << AW;

    logic          clk = 1'b0;
    logic          clr_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          din = 1'b0;
    logic [N-1:0]  q;

    int checks = 0;
    int errors = 0;
    int refq[N];
    bit done = 0;

    addr_bit_latch #(.ADDR_W(AW)) dut (
        .clk(clk), .clr_n(clr_n), .we_n(we_n), .addr(addr), .din(din), .q(q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [N-1:0] ref_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = refq[i][0];
        return v;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", tag, q, exp);
        end
    endtask

    // Drive one cycle at the falling edge, update the model at the rising
    // edge, and compare at the next falling edge.
    task automatic step(input logic c, input logic w, input int a, input logic d, input string tag);
        clr_n = c; we_n = w; addr = AW'(a); din = d;
        @(posedge clk);
        if (c && !w) refq[a] = d;
        else if (!c && !w) begin
            for (int i = 0; i < N; i++) refq[i] = 0;
            refq[a] = d;
        end else if (!c && w) begin
            for (int i = 0; i < N; i++) refq[i] = 0;
        end
        @(negedge clk);
        check(tag, ref_vec());
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: q=%b expected completion", q);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R9/R4: one clear cycle from the unknown power-up state.
        step(0, 1, 5, 1, "R9 clear from unknown");
        check("R4 reset state all zero", '0);
        // R10: width.
        checks++;
        if ($bits(q) != 8) begin
            errors++;
            $display("FAIL R10: width=%0d expected 8", $bits(q));
        end
        // R5: walk a one through every address in demux mode.
        for (int a = 0; a < N; a++) begin
            step(0, 0, a, 1, "R3 demux walk");
            check("R5 address order", N'(1) << a);
        end
        // R1/R7: write several bits while moving the address.
        step(0, 1, 0, 0, "R4 clear");
        step(1, 0, 2, 1, "R1 write bit2");
        step(1, 0, 5, 1, "R7 move addr keep bit2");
        step(1, 0, 7, 1, "R7 move addr");
        step(1, 0, 5, 0, "R1 write zero");
        check("R7 bits kept", 8'b1000_0100);
        // R6: enable rises; then R2 hold with toggling inputs.
        step(1, 1, 5, 1, "R6 enable rise keeps");
        for (int i = 0; i < 6; i++) step(1, 1, i, i[0], "R2 hold ignores inputs");
        check("R2 hold value", 8'b1000_0100);
        // R8: demux address move clears the previous bit.
        step(0, 0, 3, 1, "R3 demux bit3");
        step(0, 0, 6, 1, "R8 demux move clears bit3");
        check("R8 only bit6", 8'b0100_0000);
        step(0, 0, 6, 0, "R3 demux data zero");
        // Random mix of all four modes.
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 3);
            step(r[1], r[0], $urandom_range(0, N-1), 1'($urandom_range(0, 1)), "R1-mix random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule